// File: doc/BRIEF.md
# Shared Bus Arbiter with Silent-Master Time-Out

This block is the central arbiter for a shared parallel bus of the conventional frame/initiator-ready kind. Each of `N` masters has an active-low request line and receives an active-low grant line. The arbiter treats the bus as busy while either `frame_n` or `irdy_n` is low. It chooses owners in round-robin order: the master that most recently started a transfer becomes the lowest priority for the next decision. While a transfer is still running, the arbiter shows a pending grant to the next owner. It recomputes that pending grant every cycle, so a better-placed request that arrives late takes the grant over one cycle later.

When a granted master keeps requesting on an idle bus but never drives `frame_n` low, a time-out counter fires after `TIMEOUT` cycles. The arbiter then removes the grant, sets that master's status bit and passes the grant to the next eligible requester. The timed-out master stays locked out until it releases its request for at least one cycle. The status bits drive an interrupt through per-master enables, and a per-bit pulse clears each status bit. When no master is requesting, the grant rests on master 0.

The controller has three states. ST_PARK holds the default grant on master 0. ST_GRANT holds a grant on an idle bus while the time-out counter runs. ST_ACTIVE covers a running transfer. The transitions are:
- ST_PARK to ST_GRANT when an eligible request appears.
- ST_PARK to ST_ACTIVE when the parked master starts a transfer.
- ST_GRANT to ST_ACTIVE when the granted master starts a transfer.
- ST_GRANT to ST_GRANT, with a new owner, on a dropped request or a time-out while other requesters remain.
- ST_GRANT to ST_PARK on a dropped request or a time-out when no other requester remains.
- ST_ACTIVE to ST_GRANT when the bus goes idle and a grant is pending or a request exists.
- ST_ACTIVE to ST_PARK when the bus goes idle and nothing is requesting.

Top module: `bus_arbiter_to`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle.
- R2: After reset, with no requests and an idle bus, only `gnt_n[0]` is low, and `to_status` and `irq` are 0.
- R3: A request seen on an idle bus is granted on the next clock. Among requesters that are not locked out, the winner is the first index after the last transfer owner, counting upward and wrapping from N-1 to 0. After reset the last owner counts as N-1.
- R4: A master whose grant is low on an idle bus may start a transfer by driving `frame_n` low, even with its request high. That master then becomes the last owner, and all grants are high in the first busy cycle.
- R5: While the bus is busy (`frame_n` or `irdy_n` low), the grant one cycle later goes to the winner among the current requests. A newly raised, higher-placed request therefore replaces the pending grant. When the bus turns idle, the pending grant is kept.
- R6: If the granted master keeps its request low and the bus stays idle with no transfer start, its grant stays low for exactly `TIMEOUT` cycles. On the next clock the grant goes to the next eligible requester, or to master 0 if none remains, and `to_status` for that master is set.
- R7: A timed-out master receives no grant while its request stays low. After the request has been high for at least one clock, a new request is served normally.
- R8: If the granted master raises its request before the time-out without starting a transfer, its grant is removed on the next clock and the arbiter rearbitrates. With no eligible requester left, the grant is parked on master 0.
- R9: `irq` is 1 exactly when some `to_status` bit and the matching `irq_en` bit are both 1.
- R10: A high `status_clr[i]` for one clock clears `to_status[i]`.
- R11: A master that keeps requesting after its own transfer starts is served only after the other requesters, in the order given by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N | Active-low request, one per master |
| frame_n | input | 1 | Active-low frame of the bus (transfer start/running) |
| irdy_n | input | 1 | Active-low initiator ready of the bus |
| irq_en | input | N | Interrupt enable per status bit |
| status_clr | input | N | One-clock pulse clears the matching status bit |
| gnt_n | output | N | Active-low grant, one per master |
| to_status | output | N | Sticky time-out status per master |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle:
- the single-grant rule;
- a bound on how long any master can hold a grant with its request low on an idle bus;
- every rising status bit coincides with the removal of that master's grant;
- a locked-out master never sees a grant until it releases its request;
- the interrupt stays low when nothing enables it.

Some behaviour can only be shown by the bench's scenarios, which compute their expected values in the bench:
- the exact winner of each round-robin decision, swept over every last owner and every request mask;
- the exact cycle on which the time-out fires;
- the re-pointing of a pending grant while `irdy_n` alone keeps the bus busy;
- the one-cycle release needed to lift a lockout.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    typedef enum logic [1:0] {
        ST_PARK   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_ACTIVE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/bus_arb_rr_pick.sv
// Round-robin selector: first set candidate after index `last`, wrapping.
module bus_arb_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] pick,
    output logic             found
);
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            if (!found && cand[(int'(last) + k) % N]) begin
                found = 1'b1;
                pick  = IDX_W'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/bus_arb_timer.sv
// Counts cycles of a silent grant; flags the last one before the limit.
module bus_arb_timer #(
    parameter int LIMIT = 16,
    parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bus_arb_lockout.sv
// Per-master sticky status and lockout flags.
module bus_arb_lockout #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    input  logic [N-1:0] fire,
    input  logic [N-1:0] clr,
    output logic [N-1:0] locked,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_master
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
                locked[i] <= 1'b0;
            end else begin
                if (fire[i]) begin
                    status[i] <= 1'b1;
                end else if (clr[i]) begin
                    status[i] <= 1'b0;
                end
                if (fire[i]) begin
                    locked[i] <= 1'b1;
                end else if (req_n[i]) begin
                    locked[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bus_arbiter_to.sv
module bus_arbiter_to
    import bus_arb_pkg::*;
#(
    parameter int N       = 4,
    parameter int TIMEOUT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    input  logic         frame_n,
    input  logic         irdy_n,
    input  logic [N-1:0] irq_en,
    input  logic [N-1:0] status_clr,
    output logic [N-1:0] gnt_n,
    output logic [N-1:0] to_status,
    output logic         irq
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    arb_state_t       state, st_n;
    logic [IDX_W-1:0] owner, own_n;
    logic [IDX_W-1:0] last_owner, last_n;
    logic             gnt_on, on_n;
    logic [N-1:0]     locked, fire, eligible, elig_skip, owner_vec;
    logic [IDX_W-1:0] pick_a, pick_b;
    logic             any_a, any_b, expired, bus_idle, tmr_run, tmr_clear;

    assign bus_idle  = frame_n && irdy_n;
    assign eligible  = ~req_n & ~locked;
    assign owner_vec = N'(1) << owner;
    assign elig_skip = eligible & ~owner_vec;

    bus_arb_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick_all (
        .cand(eligible), .last(last_owner), .pick(pick_a), .found(any_a)
    );
    bus_arb_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick_skip (
        .cand(elig_skip), .last(last_owner), .pick(pick_b), .found(any_b)
    );

    assign tmr_run   = (state == ST_GRANT) && bus_idle && !req_n[owner];
    assign tmr_clear = (state != ST_GRANT) || (st_n != ST_GRANT) || (own_n != owner);

    bus_arb_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .run(tmr_run), .expired(expired)
    );

    bus_arb_lockout #(.N(N)) u_lock (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .fire(fire),
        .clr(status_clr), .locked(locked), .status(to_status)
    );

    // Next-state and next-owner decisions
    always_comb begin
        st_n   = state;
        own_n  = owner;
        on_n   = gnt_on;
        last_n = last_owner;
        fire   = '0;
        unique case (state)
            ST_PARK: begin
                own_n = '0;
                on_n  = 1'b1;
                if (!frame_n) begin
                    st_n   = ST_ACTIVE;
                    last_n = '0;
                    on_n   = 1'b0;
                end else if (any_a) begin
                    st_n  = ST_GRANT;
                    own_n = pick_a;
                end
            end
            ST_GRANT: begin
                if (!frame_n) begin
                    st_n   = ST_ACTIVE;
                    last_n = owner;
                    on_n   = 1'b0;
                end else if (req_n[owner]) begin
                    st_n  = any_a ? ST_GRANT : ST_PARK;
                    own_n = any_a ? pick_a : '0;
                end else if (expired) begin
                    fire[owner] = 1'b1;
                    st_n  = any_b ? ST_GRANT : ST_PARK;
                    own_n = any_b ? pick_b : '0;
                end
            end
            ST_ACTIVE: begin
                if (bus_idle) begin
                    if (gnt_on) begin
                        st_n = ST_GRANT;
                    end else begin
                        st_n  = any_a ? ST_GRANT : ST_PARK;
                        own_n = any_a ? pick_a : '0;
                        on_n  = 1'b1;
                    end
                end else begin
                    own_n = any_a ? pick_a : owner;
                    on_n  = any_a;
                end
            end
            default: begin
                st_n  = ST_PARK;
                own_n = '0;
                on_n  = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PARK;
            owner      <= '0;
            gnt_on     <= 1'b1;
            last_owner <= IDX_W'(N - 1);
        end else begin
            state      <= st_n;
            owner      <= own_n;
            gnt_on     <= on_n;
            last_owner <= last_n;
        end
    end

    // Outputs
    always_comb begin
        gnt_n = '1;
        if (state == ST_PARK) begin
            gnt_n[0] = locked[0];
        end else if (gnt_on) begin
            gnt_n[owner] = 1'b0;
        end
        irq = |(to_status & irq_en);
    end
endmodule

// File: rtl/bus_arb_checker.sv
module bus_arb_checker #(
    parameter int N       = 4,
    parameter int TIMEOUT = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_n,
    input logic         frame_n,
    input logic         irdy_n,
    input logic [N-1:0] irq_en,
    input logic [N-1:0] status_clr,
    input logic [N-1:0] gnt_n,
    input logic [N-1:0] to_status,
    input logic         irq
);
    localparam int HW = $clog2(TIMEOUT + 4) + 1;

    logic [HW-1:0] hold_cnt;
    logic [N-1:0]  prev_gnt, prev_stat, lk;
    logic          idle, held;

    assign idle = frame_n && irdy_n;
    assign held = |(~gnt_n & ~req_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            prev_gnt  <= '1;
            prev_stat <= '0;
            lk        <= '0;
        end else begin
            prev_gnt  <= gnt_n;
            prev_stat <= to_status;
            if (idle && held && gnt_n == prev_gnt) begin
                if (hold_cnt != '1) hold_cnt <= hold_cnt + 1'b1;
            end else if (idle && held) begin
                hold_cnt <= HW'(1);
            end else begin
                hold_cnt <= '0;
            end
            for (int i = 0; i < N; i++) begin
                if (req_n[i]) lk[i] <= 1'b0;
                else if (to_status[i] && !prev_stat[i]) lk[i] <= 1'b1;
            end
        end
    end

    assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    assert_hold_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HW'(TIMEOUT + 1));

    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (to_status != '0));

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_status_drops_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(to_status[g]) |-> ($past(!gnt_n[g]) && gnt_n[g]));

        assert_locked_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lk[g] |-> gnt_n[g]);
    end
endmodule

bind bus_arbiter_to bus_arb_checker #(.N(N), .TIMEOUT(TIMEOUT)) u_checker (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .irq_en(irq_en), .status_clr(status_clr), .gnt_n(gnt_n),
    .to_status(to_status), .irq(irq)
);

// File: tb/test_bus_arbiter_to.sv
`timescale 1ns/1ps
module test_bus_arbiter_to;
    localparam int N  = 4;
    localparam int TO = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req_n, irq_en, status_clr, gnt_n, to_status;
    logic         frame_n, irdy_n, irq;
    int           checks = 0;
    int           failures = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    bus_arbiter_to #(.N(N), .TIMEOUT(TO)) i_bus_arbiter_to (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .irq_en(irq_en), .status_clr(status_clr), .gnt_n(gnt_n),
        .to_status(to_status), .irq(irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_gnt(input string tag, input int idx);
        int exp;
        exp = (idx < 0) ? 'hF : (~(1 << idx) & 'hF);
        chk(tag, int'(gnt_n), exp);
        chk("R1 single grant", int'($countones(~gnt_n) <= 1), 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
        status_clr = '0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    function automatic int rr_exp(input int s, input int mask);
        for (int k = 1; k <= N; k++) begin
            if (mask[(s + k) % N]) return (s + k) % N;
        end
        return -1;
    endfunction

    initial begin
        #(2.5 * 2 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        irq_en = 4'b0010;
        do_reset();
        // R2 reset state
        chk_gnt("R2 parked grant", 0);
        chk("R2 status", int'(to_status), 0);
        chk("R2 irq", int'(irq), 0);

        // R3 / R11 sweep over last owner and request mask
        for (int s = 0; s < N; s++) begin
            for (int m = 1; m < (1 << N); m++) begin
                do_reset();
                req_n = ~(N'(1) << s);
                step();
                frame_n = 1'b0; req_n = '1;
                step();
                chk_gnt("R4 grant off at start", -1);
                req_n = ~N'(m);
                step();
                chk_gnt("R3 R11 rr pick", rr_exp(s, m));
                frame_n = 1'b1;
                step();
                chk_gnt("R5 pending kept", rr_exp(s, m));
            end
        end

        // R4: parked master starts without request
        do_reset();
        frame_n = 1'b0;
        step();
        chk_gnt("R4 parked start", -1);
        req_n = 4'b0110;            // masters 0 and 3 request
        step();
        chk_gnt("R4 last owner 0", 3);
        frame_n = 1'b1;
        step();
        chk_gnt("R4 grant on idle", 3);

        // R5: re-point while busy (irdy alone keeps bus busy)
        do_reset();
        req_n = 4'b1101;
        step();
        chk_gnt("R3 single req", 1);
        frame_n = 1'b0; req_n = '1;
        step();
        req_n = 4'b1110;
        step();
        chk_gnt("R5 pending 0", 0);
        frame_n = 1'b1; irdy_n = 1'b0; req_n = 4'b1010;
        step();
        chk_gnt("R5 repoint to 2", 2);
        irdy_n = 1'b1;
        step();
        chk_gnt("R5 granted 2 idle", 2);
        frame_n = 1'b0;
        step();
        step();
        chk_gnt("R11 others first", 0);
        frame_n = 1'b1;

        // R6 time-out boundary, R7 lockout, R8 drop, R9 irq, R10 clear
        do_reset();
        req_n = 4'b1001;            // masters 1 and 2
        step();
        chk_gnt("R6 granted 1", 1);
        for (int c = 1; c < TO; c++) step();
        chk_gnt("R6 still held at limit", 1);
        chk("R6 status not yet", int'(to_status), 0);
        step();
        chk_gnt("R6 moved to 2", 2);
        chk("R6 status set", int'(to_status), 2);
        chk("R9 irq on", int'(irq), 1);
        req_n = 4'b1101;            // master 2 drops, 1 still low
        step();
        chk_gnt("R8 R7 park not 1", 0);
        step(); step(); step();
        chk_gnt("R7 still ignored", 0);
        irq_en = 4'b1101;
        #1;
        chk("R9 irq masked", int'(irq), 0);
        irq_en = 4'b0010;
        #1;
        chk("R9 irq back", int'(irq), 1);
        req_n = 4'b1111;
        step();
        req_n = 4'b1101;
        step();
        chk_gnt("R7 served after release", 1);
        req_n = 4'b1111;
        step();
        chk_gnt("R8 drop before limit", 0);
        status_clr = 4'b0010;
        step();
        status_clr = '0;
        chk("R10 cleared", int'(to_status), 0);
        chk("R10 irq low", int'(irq), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule